// File: doc/BRIEF.md
# Folded FIR Filter Datapath

This block computes a finite impulse response over the last `TAPS` input samples with a single shared multiply-accumulate unit. The unit visits one tap per clock, so the block accepts a new sample only while it raises `ready_o`. Once accepted, the sample goes into a circular history buffer. The sequencer then steps through the taps, newest sample first, and reads one coefficient per cycle from an external coefficient store over a plain address/data port. The store answers in the same cycle. Loading and swapping coefficient sets is handled by a neighbouring block.

The sum is built at full precision with no rounding and no saturation. Data and coefficients are two's-complement words, and each can be configured as signed or unsigned. The output width is `DATA_W + COEF_W + ceil(log2(TAPS))`. An identifier supplied with each sample is carried along and comes out next to the matching result. There are two resets: an asynchronous active-low `rst_ni` and a synchronous active-low `srst_ni`. Both return the block to the same state.

Top module: `fir_folded`

## Requirements
- R1: After either reset, `ready_o`=1, `dout_valid_o`=0, `dout_o`=0, `coef_rd_o`=0, and every history entry reads as zero.
- R2: A sample is accepted on a rising edge where `din_valid_i` and `ready_o` are both 1. `ready_o` is then 0 for exactly `TAPS` cycles and returns to 1 after them.
- R3: `din_valid_i` asserted while `ready_o`=0 is ignored. The data it carries never enters the history and never changes any result.
- R4: The result equals the sum over k=0..TAPS-1 of coef[k]·x[n-k], where x[n] is the newest accepted sample and multiplies coef[0]. It is presented on `dout_o` at width DATA_W+COEF_W+ceil(log2 TAPS).
- R5: When DATA_SIGNED=1 or COEF_SIGNED=1, `dout_o` is a two's-complement signed value, and each operand is extended by its own signedness. When both are 0, all values, `dout_o` included, are unsigned.
- R6: `dout_valid_o` is a single-cycle pulse in the cycle after the last tap, which is the first cycle with `ready_o` high again. Between pulses `dout_o` holds its value.
- R7: `dout_id_o` shows, during the pulse, the `din_id_i` value captured with the sample that produced that result.
- R8: In busy cycle k (k=0..TAPS-1) after acceptance, `coef_rd_o`=1 and `coef_addr_o`=k. `coef_rd_o`=0 whenever `ready_o`=1.
- R9: `srst_ni` low at a rising edge aborts any accumulation in progress, suppresses its result, and restores the R1 state.
- R10: The cycle that carries `dout_valid_o` also has `ready_o`=1, so a next sample offered in that cycle is accepted with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| srst_ni | input | 1 | Synchronous reset, active low |
| din_i | input | DATA_W | Input sample |
| din_valid_i | input | 1 | Input sample strobe |
| din_id_i | input | ID_W | Identifier carried with the sample |
| ready_o | output | 1 | Block can take a sample this cycle |
| coef_rd_o | output | 1 | Coefficient read strobe |
| coef_addr_o | output | ceil(log2 TAPS) | Coefficient tap index |
| coef_i | input | COEF_W | Coefficient word for `coef_addr_o`, same cycle |
| dout_o | output | DATA_W+COEF_W+ceil(log2 TAPS) | Full-precision filter result |
| dout_valid_o | output | 1 | One-cycle result strobe |
| dout_id_o | output | ID_W | Identifier of the result |

## Verification
The result strobe for one sample and the acceptance of the next sample can fall in the same cycle, because `ready_o` returns at the moment the finished sum is registered. The bench provokes this by sending samples back to back: each sample is driven at the first cycle where ready is seen again. The scoreboard then requires that each result matches the model built from the correct history, and that ready is high in the strobe cycle. It also requires that the next burst begins with coefficient address 0 and does not corrupt the result just published. Two instances, one signed and one unsigned, share the stimulus, so the same timing is judged under both signedness rules.

// File: rtl/fir_pkg.sv
package fir_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} fir_state_e;

  function automatic int fir_out_width(input int dw, input int cw, input int taps);
    return dw + cw + $clog2(taps);
  endfunction
endpackage

// File: rtl/fir_seq.sv
module fir_seq
  import fir_pkg::*;
#(
  parameter int TAPS   = 8,
  parameter int TAP_AW = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              srst_ni,
  input  logic              start_i,
  output logic              ready_o,
  output logic              run_o,
  output logic              first_o,
  output logic              last_o,
  output logic [TAP_AW-1:0] tap_o
);
  localparam logic [TAP_AW-1:0] LAST_TAP = TAP_AW'(TAPS - 1);

  fir_state_e        state_q;
  logic [TAP_AW-1:0] tap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tap_q   <= '0;
    end else if (!srst_ni) begin
      state_q <= ST_IDLE;
      tap_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_RUN;
            tap_q   <= '0;
          end
        end
        ST_RUN: begin
          if (tap_q == LAST_TAP) begin
            state_q <= ST_IDLE;
            tap_q   <= '0;
          end else begin
            tap_q <= tap_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o = (state_q == ST_IDLE);
  assign run_o   = (state_q == ST_RUN);
  assign first_o = run_o && (tap_q == '0);
  assign last_o  = run_o && (tap_q == LAST_TAP);
  assign tap_o   = tap_q;
endmodule

// File: rtl/fir_delay_line.sv
module fir_delay_line #(
  parameter int TAPS   = 8,
  parameter int DATA_W = 16,
  parameter int TAP_AW = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              srst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [TAP_AW-1:0] tap_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam logic [TAP_AW-1:0] LAST_IDX = TAP_AW'(TAPS - 1);
  localparam logic [TAP_AW:0]   TAPS_X   = (TAP_AW + 1)'(TAPS);

  logic [TAP_AW-1:0] wr_ptr_q, head_q, rd_idx;
  logic [TAP_AW:0]   diff;
  logic [DATA_W-1:0] mem_q [TAPS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      head_q   <= LAST_IDX;
    end else if (!srst_ni) begin
      wr_ptr_q <= '0;
      head_q   <= LAST_IDX;
    end else if (wr_en_i) begin
      head_q   <= wr_ptr_q;
      wr_ptr_q <= (wr_ptr_q == LAST_IDX) ? '0 : wr_ptr_q + 1'b1;
    end
  end

  for (genvar g = 0; g < TAPS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    mem_q[g] <= '0;
      else if (!srst_ni)                              mem_q[g] <= '0;
      else if (wr_en_i && (wr_ptr_q == TAP_AW'(g)))   mem_q[g] <= wr_data_i;
    end
  end

  // tap k reads the sample written k acceptances ago
  always_comb begin
    diff   = {1'b0, head_q} - {1'b0, tap_i};
    rd_idx = diff[TAP_AW] ? TAP_AW'(diff + TAPS_X) : diff[TAP_AW-1:0];
  end

  assign rd_data_o = mem_q[rd_idx];
endmodule

// File: rtl/fir_mac.sv
module fir_mac #(
  parameter int DATA_W      = 16,
  parameter int COEF_W      = 16,
  parameter int OUT_W       = 35,
  parameter bit DATA_SIGNED = 1'b1,
  parameter bit COEF_SIGNED = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              srst_ni,
  input  logic              en_i,
  input  logic              first_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [COEF_W-1:0] coef_i,
  output logic [OUT_W-1:0]  sum_o
);
  localparam int PROD_W = DATA_W + COEF_W + 2;
  localparam int ACC_W  = OUT_W + 1;

  logic d_xbit, c_xbit;

  if (DATA_SIGNED) begin : g_dsig
    assign d_xbit = data_i[DATA_W-1];
  end else begin : g_duns
    assign d_xbit = 1'b0;
  end

  if (COEF_SIGNED) begin : g_csig
    assign c_xbit = coef_i[COEF_W-1];
  end else begin : g_cuns
    assign c_xbit = 1'b0;
  end

  logic signed [DATA_W:0]     d_ext;
  logic signed [COEF_W:0]     c_ext;
  logic signed [PROD_W-1:0]   prod;
  logic signed [ACC_W-1:0]    acc_q, base, sum;

  assign d_ext = signed'({d_xbit, data_i});
  assign c_ext = signed'({c_xbit, coef_i});
  assign prod  = PROD_W'(d_ext) * PROD_W'(c_ext);
  assign base  = first_i ? '0 : acc_q;
  assign sum   = base + ACC_W'(prod);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       acc_q <= '0;
    else if (!srst_ni) acc_q <= '0;
    else if (en_i)     acc_q <= sum;
  end

  assign sum_o = sum[OUT_W-1:0];
endmodule

// File: rtl/fir_folded.sv
module fir_folded
  import fir_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int COEF_W      = 16,
  parameter int TAPS        = 8,
  parameter int ID_W        = 4,
  parameter bit DATA_SIGNED = 1'b1,
  parameter bit COEF_SIGNED = 1'b1,
  localparam int TAP_AW     = $clog2(TAPS),
  localparam int OUT_W      = fir_out_width(DATA_W, COEF_W, TAPS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              srst_ni,
  input  logic [DATA_W-1:0] din_i,
  input  logic              din_valid_i,
  input  logic [ID_W-1:0]   din_id_i,
  output logic              ready_o,
  output logic              coef_rd_o,
  output logic [TAP_AW-1:0] coef_addr_o,
  input  logic [COEF_W-1:0] coef_i,
  output logic [OUT_W-1:0]  dout_o,
  output logic              dout_valid_o,
  output logic [ID_W-1:0]   dout_id_o
);
  logic              accept, run, first, last;
  logic [TAP_AW-1:0] tap;
  logic [DATA_W-1:0] hist_data;
  logic [OUT_W-1:0]  sum;
  logic [ID_W-1:0]   id_q;

  assign accept = din_valid_i && ready_o;

  fir_seq #(.TAPS(TAPS), .TAP_AW(TAP_AW)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .srst_ni (srst_ni),
    .start_i (accept),
    .ready_o (ready_o),
    .run_o   (run),
    .first_o (first),
    .last_o  (last),
    .tap_o   (tap)
  );

  fir_delay_line #(.TAPS(TAPS), .DATA_W(DATA_W), .TAP_AW(TAP_AW)) u_hist (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .srst_ni   (srst_ni),
    .wr_en_i   (accept),
    .wr_data_i (din_i),
    .tap_i     (tap),
    .rd_data_o (hist_data)
  );

  fir_mac #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .OUT_W(OUT_W),
    .DATA_SIGNED(DATA_SIGNED), .COEF_SIGNED(COEF_SIGNED)
  ) u_mac (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .srst_ni (srst_ni),
    .en_i    (run),
    .first_i (first),
    .data_i  (hist_data),
    .coef_i  (coef_i),
    .sum_o   (sum)
  );

  assign coef_rd_o   = run;
  assign coef_addr_o = tap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_q         <= '0;
      dout_o       <= '0;
      dout_valid_o <= 1'b0;
      dout_id_o    <= '0;
    end else if (!srst_ni) begin
      id_q         <= '0;
      dout_o       <= '0;
      dout_valid_o <= 1'b0;
      dout_id_o    <= '0;
    end else begin
      dout_valid_o <= last;
      if (accept) id_q <= din_id_i;
      if (last) begin
        dout_o    <= sum;
        dout_id_o <= id_q;
      end
    end
  end
endmodule

// File: rtl/fir_folded_chk.sv
module fir_folded_chk #(
  parameter int TAPS  = 8,
  parameter int OUT_W = 35
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             srst_ni,
  input logic             din_valid_i,
  input logic             ready_o,
  input logic             coef_rd_o,
  input logic             dout_valid_o,
  input logic [OUT_W-1:0] dout_o
);
  localparam int CW = $clog2(TAPS + 1) + 1;
  logic [CW-1:0] busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       busy_q <= '0;
    else if (!srst_ni) busy_q <= '0;
    else if (!ready_o) busy_q <= busy_q + 1'b1;
    else               busy_q <= '0;
  end

  // R2
  accept_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !srst_ni)
    (din_valid_i && ready_o) |=> !ready_o);

  // R2
  busy_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !srst_ni)
    !ready_o |-> (busy_q < CW'(TAPS)));

  // R2
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !srst_ni)
    ($rose(ready_o) && $past(srst_ni)) |-> (busy_q == CW'(TAPS)));

  // R6
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !srst_ni)
    dout_valid_o |=> !dout_valid_o);

  // R6
  dout_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dout_valid_o && $past(srst_ni)) |-> $stable(dout_o));

  // R8
  coef_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !coef_rd_o);

  // R10
  valid_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dout_valid_o |-> ready_o);
endmodule

bind fir_folded fir_folded_chk #(.TAPS(TAPS), .OUT_W(OUT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .srst_ni      (srst_ni),
  .din_valid_i  (din_valid_i),
  .ready_o      (ready_o),
  .coef_rd_o    (coef_rd_o),
  .dout_valid_o (dout_valid_o),
  .dout_o       (dout_o)
);

// File: tb/sim_fir_folded.sv
module sim_fir_folded;
  localparam int DW   = 16;
  localparam int CW   = 16;
  localparam int TAPS = 8;
  localparam int IDW  = 4;
  localparam int AW   = $clog2(TAPS);
  localparam int OW   = DW + CW + AW;

  typedef struct {
    logic [OW-1:0]  es;
    logic [OW-1:0]  eu;
    logic [IDW-1:0] id;
  } exp_t;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic           rst_n = 1'b0, srst_n = 1'b1;
  logic [DW-1:0]  din = '0;
  logic           din_vld = 1'b0;
  logic [IDW-1:0] din_id = '0;

  logic           rdy_s, rdy_u, crd_s, crd_u, vld_s, vld_u;
  logic [AW-1:0]  addr_s, addr_u;
  logic [CW-1:0]  coef_s, coef_u;
  logic [OW-1:0]  dout_s, dout_u;
  logic [IDW-1:0] id_s, id_u;

  logic [CW-1:0] cmem [TAPS];
  logic [DW-1:0] hist [TAPS];
  exp_t          sb [$];

  int  nchk = 0, nfail = 0;
  logic [OW-1:0] last_s = '0;
  logic          prev_vld = 1'b0;
  logic          mon_on = 1'b0;

  assign coef_s = cmem[addr_s];
  assign coef_u = cmem[addr_u];

  fir_folded #(.DATA_W(DW), .COEF_W(CW), .TAPS(TAPS), .ID_W(IDW),
               .DATA_SIGNED(1'b1), .COEF_SIGNED(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .srst_ni(srst_n),
    .din_i(din), .din_valid_i(din_vld), .din_id_i(din_id),
    .ready_o(rdy_s), .coef_rd_o(crd_s), .coef_addr_o(addr_s), .coef_i(coef_s),
    .dout_o(dout_s), .dout_valid_o(vld_s), .dout_id_o(id_s));

  fir_folded #(.DATA_W(DW), .COEF_W(CW), .TAPS(TAPS), .ID_W(IDW),
               .DATA_SIGNED(1'b0), .COEF_SIGNED(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .srst_ni(srst_n),
    .din_i(din), .din_valid_i(din_vld), .din_id_i(din_id),
    .ready_o(rdy_u), .coef_rd_o(crd_u), .coef_addr_o(addr_u), .coef_i(coef_u),
    .dout_o(dout_u), .dout_valid_o(vld_u), .dout_id_o(id_u));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic exp_t model(input logic [IDW-1:0] id);
    longint s = 0, u = 0;
    exp_t e;
    for (int k = 0; k < TAPS; k++) begin
      s += longint'(signed'(hist[k])) * longint'(signed'(cmem[k]));
      u += longint'(hist[k]) * longint'(cmem[k]);
    end
    e.es = OW'(s);
    e.eu = OW'(u);
    e.id = id;
    return e;
  endfunction

  // called at a negedge; returns at the negedge where ready is back
  task automatic send(input logic [DW-1:0] d, input logic [IDW-1:0] id, input bit junk);
    while (!rdy_s) @(negedge clk);
    din = d; din_id = id; din_vld = 1'b1;
    for (int k = TAPS - 1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = d;
    sb.push_back(model(id));
    @(negedge clk);
    din_vld = junk;
    din = ~d ^ 16'h5a5a;
    din_id = ~id;
    for (int k = 0; k < TAPS; k++) begin
      // R2 busy, R8 coefficient index
      chk(!rdy_s && !rdy_u, "R2 busy", {63'd0, rdy_s}, 64'd0);
      chk(crd_s && addr_s == AW'(k), "R8 addr", {31'd0, crd_s, 32'(addr_s)}, {32'd1, 32'(k)});
      if (k == TAPS - 2) din_vld = 1'b0;
      @(negedge clk);
    end
    chk(rdy_s && rdy_u, "R2 ready back", {63'd0, rdy_s}, 64'd1);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (mon_on) begin
      chk(vld_s == vld_u, "R5 lockstep", {63'd0, vld_u}, {63'd0, vld_s});
      if (vld_s) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R6 unexpected result", {29'd0, dout_s}, 64'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          // R4 R5 signed result
          chk(dout_s == e.es, "R4 signed sum", {29'd0, dout_s}, {29'd0, e.es});
          // R5 unsigned instance
          chk(dout_u == e.eu, "R5 unsigned sum", {29'd0, dout_u}, {29'd0, e.eu});
          // R7
          chk(id_s == e.id && id_u == e.id, "R7 id", {60'd0, id_s}, {60'd0, e.id});
        end
        // R10
        chk(rdy_s, "R10 ready with valid", {63'd0, rdy_s}, 64'd1);
        // R6
        chk(!prev_vld, "R6 single pulse", {63'd0, prev_vld}, 64'd0);
        last_s = dout_s;
      end else begin
        // R6
        chk(dout_s == last_s, "R6 hold", {29'd0, dout_s}, {29'd0, last_s});
      end
      prev_vld = vld_s;
    end
  end

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cmem[0] = 16'h0001; cmem[1] = 16'hFFFF; cmem[2] = 16'h8000; cmem[3] = 16'h7FFF;
    cmem[4] = 16'h0123; cmem[5] = 16'hFE00; cmem[6] = 16'h0040; cmem[7] = 16'h1000;
    for (int k = 0; k < TAPS; k++) hist[k] = '0;

    repeat (3) @(negedge clk);
    // R1 asynchronous reset state
    chk(rdy_s && !vld_s && dout_s == '0 && !crd_s, "R1 reset", {29'd0, dout_s}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rdy_s && rdy_u && !vld_u && dout_u == '0, "R1 after release", {63'd0, rdy_s}, 64'd1);
    mon_on = 1'b1;

    // R4 impulse walks the coefficients out in order; R1 zero history
    send(16'h0001, 4'h1, 1'b0);
    for (int k = 1; k < TAPS; k++) send(16'h0000, IDW'(k + 1), 1'b0);

    // R5 extreme values, back to back (R10)
    send(16'h8000, 4'h3, 1'b0);
    send(16'hFFFF, 4'h4, 1'b0);
    send(16'h7FFF, 4'h5, 1'b0);
    send(16'h8001, 4'h6, 1'b0);
    for (int k = 0; k < 6; k++) send(16'(16'h1357 * (k + 3)), IDW'(k), 1'b0);

    // R3 valid held high with other data while busy
    send(16'h0042, 4'h9, 1'b1);
    send(16'hC000, 4'hA, 1'b1);
    repeat (5) @(negedge clk);
    send(16'h2468, 4'hB, 1'b0);
    repeat (3) @(negedge clk);

    // R9 synchronous reset mid-accumulation
    din = 16'h7777; din_id = 4'hC; din_vld = 1'b1;
    @(negedge clk);
    din_vld = 1'b0;
    repeat (3) @(negedge clk);
    srst_n = 1'b0;
    @(posedge clk);
    #1;
    last_s = '0;
    for (int k = 0; k < TAPS; k++) hist[k] = '0;
    @(negedge clk);
    srst_n = 1'b1;
    chk(rdy_s && !crd_s && !vld_s && dout_s == '0 && id_s == '0, "R9 sync reset", {29'd0, dout_s}, 64'd0);
    repeat (TAPS + 2) @(negedge clk);
    chk(sb.size() == 0, "R9 aborted result", 64'(sb.size()), 64'd0);
    // R9 history cleared: single sample yields coef0 * x
    send(16'hFFF0, 4'hD, 1'b0);
    send(16'h0003, 4'hE, 1'b0);

    repeat (4) @(negedge clk);
    chk(sb.size() == 0, "R6 all results seen", 64'(sb.size()), 64'd0);
    finish_run();
  end
endmodule